// File: doc/BRIEF.md
# UART Host Register Access Front End

This block sits between a processor bus and the register file of a 16550-style serial port. It takes a three-bit register select, three chip-select lines and an address strobe. It also takes read and write strobes that are synchronous to the block clock. From these it works out which internal register an access targets. It holds the line control, interrupt enable, modem control, scratch and divisor bytes itself. Values owned by other units come in on input ports: the receive buffer, interrupt identification, line status and modem status. The block returns them on an 8-bit read data bus.

The most significant bit of the line control byte is the divisor access bit. It redirects slots 0 and 1 to the divisor bytes. The address strobe can freeze the select and chip-select lines so that they need not stay stable for the whole access. Downstream logic gets a one-hot write-enable vector that shares the write data bus. It also gets one-cycle pulses when a read must have a side effect: popping the receive buffer, or clearing the modem-status delta bits. A low-active driver-disable output steers an external bus transceiver during reads.

Top module: `uart_host_regif`

## Requirements
- R1: The block is selected only when `cs_hi0`=1, `cs_hi1`=1 and `cs_lo_n`=0. When it is not selected, `wr_en` is all zero, `rd_data` is 0, `drv_dis_n` is 1 and no pulse is produced.
- R2: With the divisor access bit (`lcr_q[7]`) at 0, a read returns the following. Slot 0 gives `rx_buf_data`. Slot 1 gives the interrupt enable byte. Slot 2 gives `int_id_data`.
- R3: `wr_en` bit order is 0 transmit holding, 1 interrupt enable, 2 FIFO control, 3 line control, 4 modem control, 5 line status, 6 modem status, 7 scratch, 8 divisor low, 9 divisor high. With the divisor access bit at 0, a selected write to slot 0, 1 or 2 raises only bit 0, 1 or 2 respectively.
- R4: Slots 3 to 7 map to line control, modem control, line status, modem status and scratch, in that order, for reads and writes, whatever the divisor access bit is. Reading slots 5 and 6 returns `line_stat_data` and `modem_stat_data`.
- R5: With the divisor access bit at 1, slot 0 reads and writes the divisor low byte (`wr_en` bit 8), and slot 1 reads and writes the divisor high byte (bit 9). `div_q` is {high, low}.
- R6: While `addr_stb` is low, select and chip-select pass straight through. While `addr_stb` is high, the decode uses the values sampled on the last clock edge at which `addr_stb` was low.
- R7: `drv_dis_n` is 0 exactly while a selected read strobe is active.
- R8: The first cycle of a selected read of slot 0 with the divisor access bit at 0 raises `rx_buf_rd_pulse` for exactly one cycle. A divisor read of slot 0 does not raise it.
- R9: The first cycle of a selected read of slot 6 raises `msr_rd_pulse` for exactly one cycle.
- R10: The scratch byte reads back the last value written to it, and accessing it produces no pulse.
- R11: Reset clears the line control, interrupt enable and modem control bytes, so the divisor access bit returns to 0. Reset leaves the divisor and scratch bytes unchanged.
- R12: A written byte updates on the clock edge of the write and reads back from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_sel | input | 3 | Register slot select |
| cs_hi0 | input | 1 | Chip select, active high |
| cs_hi1 | input | 1 | Chip select, active high |
| cs_lo_n | input | 1 | Chip select, active low |
| addr_stb | input | 1 | Address strobe; high holds the sampled select and chip select |
| rd_stb | input | 1 | Read strobe, level, synchronous |
| wr_stb | input | 1 | Write strobe, level, synchronous |
| wr_data | input | 8 | Write data, shared by all targets |
| rx_buf_data | input | 8 | Receive buffer head byte |
| int_id_data | input | 8 | Interrupt identification byte |
| line_stat_data | input | 8 | Line status byte |
| modem_stat_data | input | 8 | Modem status byte |
| rd_data | output | 8 | Read data, 0 when no selected read |
| drv_dis_n | output | 1 | Low while the host reads |
| wr_en | output | 10 | One-hot write enables |
| rx_buf_rd_pulse | output | 1 | Receive buffer pop pulse |
| msr_rd_pulse | output | 1 | Modem status delta clear pulse |
| ier_q | output | 8 | Interrupt enable byte |
| lcr_q | output | 8 | Line control byte |
| mcr_q | output | 8 | Modem control byte |
| div_q | output | 16 | Divisor {high, low} |

## Verification
The assertions assume that `rd_stb` and `wr_stb` never rise together. They also assume each access strobe drops for at least one cycle before the next access, so every read is a fresh access with its own first cycle. The bench therefore issues one strobe at a time. Each strobe is raised on a falling clock edge and dropped on the next falling edge, or one edge later for reads. Select, chip-select and address-strobe changes are applied on falling edges as well, so the latch always samples settled values.

// File: rtl/uart_hri_pkg.sv
package uart_hri_pkg;
  localparam int DATA_W = 8;
  localparam int SEL_W  = 3;
  localparam int NUM_WE = 10;

  // write enable bit positions (decoded downstream)
  localparam int WE_TXH = 0;
  localparam int WE_IEN = 1;
  localparam int WE_FCT = 2;
  localparam int WE_LCT = 3;
  localparam int WE_MCT = 4;
  localparam int WE_LST = 5;
  localparam int WE_MST = 6;
  localparam int WE_SCR = 7;
  localparam int WE_DVL = 8;
  localparam int WE_DVH = 9;

  typedef enum logic [3:0] {
    RT_NONE = 4'd0,
    RT_RXB  = 4'd1,
    RT_IEN  = 4'd2,
    RT_IID  = 4'd3,
    RT_LCT  = 4'd4,
    RT_MCT  = 4'd5,
    RT_LST  = 4'd6,
    RT_MST  = 4'd7,
    RT_SCR  = 4'd8,
    RT_DVL  = 4'd9,
    RT_DVH  = 4'd10
  } rd_tgt_e;
endpackage

// File: rtl/hri_sel_latch.sv
module hri_sel_latch #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             addr_stb,
  input  logic [SEL_W-1:0] sel_in,
  input  logic             cs_in,
  output logic [SEL_W-1:0] sel_eff,
  output logic             cs_eff
);
  logic [SEL_W-1:0] sel_q, sel_d;
  logic             cs_q, cs_d;
  logic             cap_en;

  // sample while the strobe is low, hold once it has risen
  assign cap_en = ~addr_stb;

  always_comb begin
    sel_d = sel_q;
    cs_d  = cs_q;
    if (cap_en) begin
      sel_d = sel_in;
      cs_d  = cs_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      cs_q  <= 1'b0;
    end else begin
      sel_q <= sel_d;
      cs_q  <= cs_d;
    end
  end

  assign sel_eff = addr_stb ? sel_q : sel_in;
  assign cs_eff  = addr_stb ? cs_q  : cs_in;

  assert_sel_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_stb && $past(addr_stb)) |-> ($stable(sel_eff) && $stable(cs_eff)));
  assert_sel_transparent_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!addr_stb) |-> (sel_eff == sel_in && cs_eff == cs_in));
endmodule

// File: rtl/hri_decode.sv
module hri_decode
  import uart_hri_pkg::*;
#(
  parameter int SEL_W = 3
) (
  input  logic              [SEL_W-1:0]  sel,
  input  logic                           dlab,
  input  logic                           cs,
  input  logic                           wr_stb,
  output rd_tgt_e                        rd_tgt,
  output logic              [NUM_WE-1:0] wr_en
);
  int wr_idx;

  always_comb begin
    rd_tgt = RT_NONE;
    wr_idx = WE_TXH;
    unique case (sel)
      3'd0: begin
        rd_tgt = dlab ? RT_DVL : RT_RXB;
        wr_idx = dlab ? WE_DVL : WE_TXH;
      end
      3'd1: begin
        rd_tgt = dlab ? RT_DVH : RT_IEN;
        wr_idx = dlab ? WE_DVH : WE_IEN;
      end
      3'd2: begin rd_tgt = RT_IID; wr_idx = WE_FCT; end
      3'd3: begin rd_tgt = RT_LCT; wr_idx = WE_LCT; end
      3'd4: begin rd_tgt = RT_MCT; wr_idx = WE_MCT; end
      3'd5: begin rd_tgt = RT_LST; wr_idx = WE_LST; end
      3'd6: begin rd_tgt = RT_MST; wr_idx = WE_MST; end
      default: begin rd_tgt = RT_SCR; wr_idx = WE_SCR; end
    endcase
    if (!cs) rd_tgt = RT_NONE;
  end

  always_comb begin
    wr_en = '0;
    for (int i = 0; i < NUM_WE; i++) begin
      if (cs && wr_stb && (wr_idx == i)) wr_en[i] = 1'b1;
    end
  end
endmodule

// File: rtl/hri_regbank.sv
module hri_regbank
  import uart_hri_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_WE-1:0]       wr_en,
  input  logic [DATA_W-1:0]       wr_data,
  output logic [DATA_W-1:0]       ier_q,
  output logic [DATA_W-1:0]       lcr_q,
  output logic [DATA_W-1:0]       mcr_q,
  output logic [DATA_W-1:0]       scr_q,
  output logic [2*DATA_W-1:0]     div_q
);
  // which write targets are stored here, and which of those reset
  localparam logic [NUM_WE-1:0] STORE_MASK = 10'b11_1001_1010;
  localparam logic [NUM_WE-1:0] RST_MASK   = 10'b00_0001_1010;

  logic [DATA_W-1:0] bank [NUM_WE];

  for (genvar i = 0; i < NUM_WE; i++) begin : g_byte
    if (STORE_MASK[i] && RST_MASK[i]) begin : g_rst
      logic [DATA_W-1:0] r_q, r_d;
      always_comb r_d = wr_en[i] ? wr_data : r_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
      end
      assign bank[i] = r_q;
    end else if (STORE_MASK[i]) begin : g_keep
      logic [DATA_W-1:0] r_q;
      always_ff @(posedge clk) begin
        if (wr_en[i]) r_q <= wr_data;
      end
      assign bank[i] = r_q;
    end else begin : g_none
      assign bank[i] = '0;
    end
  end

  assign ier_q = bank[WE_IEN];
  assign lcr_q = bank[WE_LCT];
  assign mcr_q = bank[WE_MCT];
  assign scr_q = bank[WE_SCR];
  assign div_q = {bank[WE_DVH], bank[WE_DVL]};

  assert_lcr_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en[WE_LCT] |=> (lcr_q == $past(wr_data)));
  assert_scr_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en[WE_SCR] && $past(wr_en[WE_SCR] == 1'b0)) |=> $stable(scr_q));
  assert_div_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en[WE_DVH] |=> (div_q[2*DATA_W-1:DATA_W] == $past(wr_data)));
endmodule

// File: rtl/uart_host_regif.sv
module uart_host_regif
  import uart_hri_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    reg_sel,
  input  logic          cs_hi0,
  input  logic          cs_hi1,
  input  logic          cs_lo_n,
  input  logic          addr_stb,
  input  logic          rd_stb,
  input  logic          wr_stb,
  input  logic [DW-1:0] wr_data,
  input  logic [DW-1:0] rx_buf_data,
  input  logic [DW-1:0] int_id_data,
  input  logic [DW-1:0] line_stat_data,
  input  logic [DW-1:0] modem_stat_data,
  output logic [DW-1:0] rd_data,
  output logic          drv_dis_n,
  output logic [9:0]    wr_en,
  output logic          rx_buf_rd_pulse,
  output logic          msr_rd_pulse,
  output logic [DW-1:0] ier_q,
  output logic [DW-1:0] lcr_q,
  output logic [DW-1:0] mcr_q,
  output logic [2*DW-1:0] div_q
);
  localparam int DLAB_BIT = DW - 1;

  // reset: asserted asynchronously, released through two flops
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic          cs_raw, cs_eff;
  logic [2:0]    sel_eff;
  rd_tgt_e       rd_tgt;
  logic [DW-1:0] scr_q;
  logic          dlab;

  assign cs_raw = cs_hi0 & cs_hi1 & ~cs_lo_n;
  assign dlab   = lcr_q[DLAB_BIT];

  hri_sel_latch #(.SEL_W(3)) u_latch (
    .clk(clk), .rst_n(rst_int_n), .addr_stb(addr_stb),
    .sel_in(reg_sel), .cs_in(cs_raw),
    .sel_eff(sel_eff), .cs_eff(cs_eff)
  );

  hri_decode #(.SEL_W(3)) u_dec (
    .sel(sel_eff), .dlab(dlab), .cs(cs_eff), .wr_stb(wr_stb),
    .rd_tgt(rd_tgt), .wr_en(wr_en)
  );

  hri_regbank #(.DATA_W(DW)) u_bank (
    .clk(clk), .rst_n(rst_int_n), .wr_en(wr_en), .wr_data(wr_data),
    .ier_q(ier_q), .lcr_q(lcr_q), .mcr_q(mcr_q), .scr_q(scr_q), .div_q(div_q)
  );

  // read path
  logic rd_access;
  assign rd_access = cs_eff & rd_stb;
  assign drv_dis_n = ~rd_access;

  always_comb begin
    rd_data = '0;
    if (rd_access) begin
      unique case (rd_tgt)
        RT_RXB:  rd_data = rx_buf_data;
        RT_IEN:  rd_data = ier_q;
        RT_IID:  rd_data = int_id_data;
        RT_LCT:  rd_data = lcr_q;
        RT_MCT:  rd_data = mcr_q;
        RT_LST:  rd_data = line_stat_data;
        RT_MST:  rd_data = modem_stat_data;
        RT_SCR:  rd_data = scr_q;
        RT_DVL:  rd_data = div_q[DW-1:0];
        RT_DVH:  rd_data = div_q[2*DW-1:DW];
        default: rd_data = '0;
      endcase
    end
  end

  // read side effects: first cycle of each read access only
  logic rd_prev_q, rd_prev_d, rd_first;
  always_comb rd_prev_d = rd_access;
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) rd_prev_q <= 1'b0;
    else            rd_prev_q <= rd_prev_d;
  end
  assign rd_first        = rd_access & ~rd_prev_q;
  assign rx_buf_rd_pulse = rd_first & (rd_tgt == RT_RXB);
  assign msr_rd_pulse    = rd_first & (rd_tgt == RT_MST);

  assert_nosel_quiet_R1: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!cs_eff) |-> (wr_en == '0 && drv_dis_n && !rx_buf_rd_pulse && !msr_rd_pulse));
  assert_wr_onehot_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    $onehot0(wr_en));
  assert_drv_dis_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!drv_dis_n) |-> rd_stb);
  assert_rx_pulse_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    rx_buf_rd_pulse |=> !rx_buf_rd_pulse);
  assert_rx_dlab_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    rx_buf_rd_pulse |-> !dlab);
  assert_msr_pulse_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    msr_rd_pulse |=> !msr_rd_pulse);
endmodule

// File: tb/sim_uart_host_regif.sv
module sim_uart_host_regif;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  reg_sel;
  logic        cs_hi0, cs_hi1, cs_lo_n, addr_stb, rd_stb, wr_stb;
  logic [7:0]  wr_data, rx_buf_data, int_id_data, line_stat_data, modem_stat_data;
  logic [7:0]  rd_data, ier_q, lcr_q, mcr_q;
  logic        drv_dis_n, rx_buf_rd_pulse, msr_rd_pulse;
  logic [9:0]  wr_en;
  logic [15:0] div_q;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // captured results of the last access
  logic [9:0] last_we;
  logic [7:0] last_rd;
  logic       last_dd, last_rxp, last_msp, last_rxp2, last_msp2;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_host_regif u0 (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel),
    .cs_hi0(cs_hi0), .cs_hi1(cs_hi1), .cs_lo_n(cs_lo_n),
    .addr_stb(addr_stb), .rd_stb(rd_stb), .wr_stb(wr_stb), .wr_data(wr_data),
    .rx_buf_data(rx_buf_data), .int_id_data(int_id_data),
    .line_stat_data(line_stat_data), .modem_stat_data(modem_stat_data),
    .rd_data(rd_data), .drv_dis_n(drv_dis_n), .wr_en(wr_en),
    .rx_buf_rd_pulse(rx_buf_rd_pulse), .msr_rd_pulse(msr_rd_pulse),
    .ier_q(ier_q), .lcr_q(lcr_q), .mcr_q(mcr_q), .div_q(div_q)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [2:0] sel, input logic [7:0] d);
    @(negedge clk);
    reg_sel = sel; wr_data = d; wr_stb = 1'b1;
    #1 last_we = wr_en;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic do_read(input logic [2:0] sel);
    @(negedge clk);
    reg_sel = sel; rd_stb = 1'b1;
    #1;
    last_rd = rd_data; last_dd = drv_dis_n;
    last_rxp = rx_buf_rd_pulse; last_msp = msr_rd_pulse;
    @(negedge clk);
    #1;
    last_rxp2 = rx_buf_rd_pulse; last_msp2 = msr_rd_pulse;
    @(negedge clk);
    rd_stb = 1'b0;
    #1 chk("R7 drv_dis_n after read", drv_dis_n, 1'b1);
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset_state();
    chk("R11 lcr after reset", lcr_q, 8'h00);
    chk("R11 ier after reset", ier_q, 8'h00);
    chk("R11 mcr after reset", mcr_q, 8'h00);
    chk("R7 drv_dis_n idle", drv_dis_n, 1'b1);
    chk("R1 rd_data idle", rd_data, 8'h00);
  endtask

  task automatic t_divisor();
    do_write(3'd3, 8'h83);
    chk("R3 lcr write enable bit3", last_we, 10'h008);
    chk("R12 lcr written", lcr_q, 8'h83);
    do_write(3'd0, 8'h34);
    chk("R5 slot0 dlab1 enable bit8", last_we, 10'h100);
    do_write(3'd1, 8'h12);
    chk("R5 slot1 dlab1 enable bit9", last_we, 10'h200);
    chk("R5 div_q", div_q, 16'h1234);
    do_read(3'd0);
    chk("R5 read divisor low", last_rd, 8'h34);
    chk("R8 no rx pulse on divisor read", last_rxp, 1'b0);
    do_read(3'd1);
    chk("R5 read divisor high", last_rd, 8'h12);
    do_read(3'd3);
    chk("R4 lcr read dlab1", last_rd, 8'h83);
    do_read(3'd5);
    chk("R4 lsr read dlab1", last_rd, line_stat_data);
  endtask

  task automatic t_normal_map();
    do_write(3'd3, 8'h03);
    do_write(3'd0, 8'h55);
    chk("R3 slot0 enable bit0", last_we, 10'h001);
    chk("R3 divisor untouched", div_q, 16'h1234);
    do_write(3'd1, 8'h0F);
    chk("R3 slot1 enable bit1", last_we, 10'h002);
    do_write(3'd2, 8'hC7);
    chk("R3 slot2 enable bit2", last_we, 10'h004);
    do_write(3'd4, 8'h0B);
    chk("R4 slot4 enable bit4", last_we, 10'h010);
    do_write(3'd5, 8'h00);
    chk("R4 slot5 enable bit5", last_we, 10'h020);
    do_write(3'd6, 8'h00);
    chk("R4 slot6 enable bit6", last_we, 10'h040);
    do_read(3'd0);
    chk("R2 read rx buffer", last_rd, rx_buf_data);
    chk("R7 drv_dis_n during read", last_dd, 1'b0);
    chk("R8 rx pulse first cycle", last_rxp, 1'b1);
    chk("R8 rx pulse gone second cycle", last_rxp2, 1'b0);
    chk("R8 no msr pulse on rx read", last_msp, 1'b0);
    do_read(3'd1);
    chk("R2 read ier", last_rd, 8'h0F);
    chk("R8 no rx pulse on ier read", last_rxp, 1'b0);
    do_read(3'd2);
    chk("R2 read int id", last_rd, int_id_data);
    do_read(3'd4);
    chk("R4 read mcr", last_rd, 8'h0B);
    do_read(3'd6);
    chk("R4 read msr", last_rd, modem_stat_data);
    chk("R9 msr pulse first cycle", last_msp, 1'b1);
    chk("R9 msr pulse gone second cycle", last_msp2, 1'b0);
  endtask

  task automatic t_scratch();
    do_write(3'd7, 8'hA5);
    chk("R10 scratch enable bit7", last_we, 10'h080);
    do_read(3'd7);
    chk("R10 scratch readback", last_rd, 8'hA5);
    chk("R10 no pulses", {last_rxp, last_msp}, 2'b00);
    do_write(3'd7, 8'h3C);
    do_read(3'd7);
    chk("R10 scratch rewrite", last_rd, 8'h3C);
  endtask

  task automatic t_chip_select();
    for (int k = 0; k < 8; k++) begin
      if (k == 3'b110) continue;
      @(negedge clk);
      {cs_hi0, cs_hi1, cs_lo_n} = 3'(k);
      reg_sel = 3'd0; wr_data = 8'hEE; wr_stb = 1'b1;
      #1 chk("R1 no write enable unselected", wr_en, 10'h000);
      @(negedge clk);
      wr_stb = 1'b0; rd_stb = 1'b1;
      #1;
      chk("R1 rd_data zero unselected", rd_data, 8'h00);
      chk("R1 drv_dis_n high unselected", drv_dis_n, 1'b1);
      chk("R1 no pulse unselected", rx_buf_rd_pulse, 1'b0);
      @(negedge clk);
      rd_stb = 1'b0;
    end
    @(negedge clk);
    {cs_hi0, cs_hi1, cs_lo_n} = 3'b110;
    do_read(3'd1);
    chk("R1 ier unchanged by unselected writes", last_rd, 8'h0F);
  endtask

  task automatic t_addr_latch();
    @(negedge clk);
    reg_sel = 3'd7; addr_stb = 1'b0;
    @(negedge clk);
    addr_stb = 1'b1;
    reg_sel = 3'd4;
    {cs_hi0, cs_hi1, cs_lo_n} = 3'b000;
    @(negedge clk);
    rd_stb = 1'b1;
    #1;
    chk("R6 held select reads scratch", rd_data, 8'h3C);
    chk("R6 held chip select", drv_dis_n, 1'b0);
    @(negedge clk);
    rd_stb = 1'b0;
    addr_stb = 1'b0;
    {cs_hi0, cs_hi1, cs_lo_n} = 3'b110;
    @(negedge clk);
    rd_stb = 1'b1;
    #1 chk("R6 transparent select reads mcr", rd_data, 8'h0B);
    @(negedge clk);
    rd_stb = 1'b0;
  endtask

  task automatic t_reset_retain();
    do_write(3'd7, 8'h5A);
    apply_reset();
    chk("R11 lcr cleared", lcr_q, 8'h00);
    chk("R11 ier cleared", ier_q, 8'h00);
    chk("R11 mcr cleared", mcr_q, 8'h00);
    chk("R11 divisor kept", div_q, 16'h1234);
    do_read(3'd7);
    chk("R11 scratch kept", last_rd, 8'h5A);
    do_read(3'd0);
    chk("R11 slot0 is rx buffer after reset", last_rd, rx_buf_data);
  endtask

  initial begin
    rst_n = 1'b0; reg_sel = '0; addr_stb = 1'b0; rd_stb = 1'b0; wr_stb = 1'b0;
    {cs_hi0, cs_hi1, cs_lo_n} = 3'b110;
    wr_data = '0; rx_buf_data = 8'h9D; int_id_data = 8'hC1;
    line_stat_data = 8'h60; modem_stat_data = 8'hB3;
    apply_reset();
    t_reset_state();
    t_divisor();
    t_normal_map();
    t_scratch();
    t_chip_select();
    t_addr_latch();
    t_reset_retain();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule